// File: doc/BRIEF.md
# Banked Index Register File with Byte Parity

This block holds the index registers of a processor with four interrupt priority levels. Each level owns a private bank of seven 16-bit index registers, numbered 1 to 7. The processor's address-generation and arithmetic logic reads and writes the bank of the level that is running, named on `level_i`. An operator console has a separate port that can read or change any register of any level. The console names its level explicitly and does not use the running level.

Each stored word carries one odd-parity bit per data byte. The parity bits are computed whenever the word is written. They are checked whenever the word is read, on either port. Both read ports are registered: the data and the parity-error flag for an address presented at one clock edge appear together after that edge. Register number 0 means "no index register". Reading it gives zero, and writing it does nothing.

Top module: `ixr_file`

## Requirements
- R1: After reset, every register of every level reads as 0x0000 with no parity error, on both read ports.
- R2: A value written through the processor port to (running level, number 1..7) appears on `rd_data_o` after the first clock edge at which that register is addressed on the read side, from the edge after the write onward.
- R3: The four level banks are independent: a write at one level leaves the register with the same number at every other level unchanged.
- R4: Number 0 selects no register. A read of number 0 returns 0x0000 with the parity-error output low. A write to number 0 changes no register.
- R5: Stored parity is odd per byte. Bit 17 covers data bits 15:8, and bit 16 covers data bits 7:0. When either byte of the addressed word fails odd parity, the read port raises its parity-error output in the same cycle as the (uncorrected) read data.
- R6: The console port reads and writes the bank chosen by `con_level_i`, whatever the value of `level_i`.
- R7: When a console write and a processor write hit the same register in the same cycle, the stored result is the console data.
- R8: A read that addresses a register in the same cycle it is written returns the value held before that write.
- R9: Every word written through either port reads back with the parity-error output low, for any data pattern.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| level_i | input | 2 | Running priority level, selects the bank for the processor ports |
| wr_en_i | input | 1 | Processor write strobe |
| wr_num_i | input | 3 | Processor write register number (0 = none) |
| wr_data_i | input | 16 | Processor write data |
| rd_num_i | input | 3 | Processor read register number (0 = none) |
| rd_data_o | output | 16 | Processor read data, one cycle after the address |
| rd_perr_o | output | 1 | Parity error on the processor read, aligned with `rd_data_o` |
| con_level_i | input | 2 | Console level select |
| con_we_i | input | 1 | Console write strobe |
| con_num_i | input | 3 | Console register number (0 = none) |
| con_wdata_i | input | 16 | Console write data |
| con_rdata_o | output | 16 | Console read data, one cycle after the address |
| con_perr_o | output | 1 | Parity error on the console read, aligned with `con_rdata_o` |

## Verification
The bench plants words with a corrupted high byte, a corrupted low byte, and a word whose parity is correct but unusual. A design that computes parity over the whole word, uses even parity, or swaps the byte-to-bit mapping flags the wrong cases. It writes the same register number at several levels. A design that ignores the level, or decodes it on the wrong port, shows values leaking between banks or the console following `level_i`. It also covers number 0, collisions between the console and the processor, and read-during-write. A design that maps number 0 onto register 1, lets the processor win a collision, or forwards write data to the read port returns values that differ from the expected ones.

// File: rtl/ixr_pkg.sv
package ixr_pkg;
    localparam int unsigned BYTE_W = 8;

    function automatic logic odd_bit(input logic [BYTE_W-1:0] b);
        return ~(^b);
    endfunction
endpackage

// File: rtl/ixr_cell.sv
module ixr_cell #(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned PAR_W  = DATA_W / ixr_pkg::BYTE_W,
    localparam int unsigned WORD_W = DATA_W + PAR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [WORD_W-1:0] word_o
);
    logic [PAR_W-1:0]  par_new;
    logic [WORD_W-1:0] word_q;

    for (genvar b = 0; b < PAR_W; b++) begin : g_par
        assign par_new[b] = ixr_pkg::odd_bit(wdata[b*ixr_pkg::BYTE_W +: ixr_pkg::BYTE_W]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= {{PAR_W{1'b1}}, {DATA_W{1'b0}}};
        end else if (we) begin
            word_q <= {par_new, wdata};
        end
    end

    assign word_o = word_q;
endmodule

// File: rtl/ixr_rdport.sv
module ixr_rdport #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LEVELS = 4,
    parameter int unsigned REGS   = 7,
    localparam int unsigned PAR_W  = DATA_W / ixr_pkg::BYTE_W,
    localparam int unsigned WORD_W = DATA_W + PAR_W,
    localparam int unsigned LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int unsigned NUM_W  = $clog2(REGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] words_i [LEVELS][REGS],
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic [NUM_W-1:0]  num_i,
    output logic [DATA_W-1:0] data_o,
    output logic              perr_o
);
    logic              hit;
    logic [WORD_W-1:0] sel_word;
    logic [PAR_W-1:0]  byte_bad;
    logic [NUM_W-1:0]  idx;

    assign idx = num_i - NUM_W'(1);

    always_comb begin
        hit      = (num_i != '0) && (num_i <= NUM_W'(REGS));
        sel_word = '0;
        if (hit) begin
            sel_word = words_i[lvl_i][idx];
        end
    end

    for (genvar b = 0; b < PAR_W; b++) begin : g_chk
        assign byte_bad[b] = ~(^{sel_word[DATA_W + b],
                                 sel_word[b*ixr_pkg::BYTE_W +: ixr_pkg::BYTE_W]});
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_o <= '0;
            perr_o <= 1'b0;
        end else begin
            data_o <= hit ? sel_word[DATA_W-1:0] : '0;
            perr_o <= hit && (|byte_bad);
        end
    end
endmodule

// File: rtl/ixr_file.sv
module ixr_file #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LEVELS = 4,
    parameter int unsigned REGS   = 7,
    localparam int unsigned PAR_W  = DATA_W / ixr_pkg::BYTE_W,
    localparam int unsigned WORD_W = DATA_W + PAR_W,
    localparam int unsigned LVL_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int unsigned NUM_W  = $clog2(REGS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LVL_W-1:0]  level_i,
    input  logic              wr_en_i,
    input  logic [NUM_W-1:0]  wr_num_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [NUM_W-1:0]  rd_num_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              rd_perr_o,
    input  logic [LVL_W-1:0]  con_level_i,
    input  logic              con_we_i,
    input  logic [NUM_W-1:0]  con_num_i,
    input  logic [DATA_W-1:0] con_wdata_i,
    output logic [DATA_W-1:0] con_rdata_o,
    output logic              con_perr_o
);
    logic [WORD_W-1:0] words [LEVELS][REGS];

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        for (genvar r = 0; r < REGS; r++) begin : g_reg
            logic              con_hit;
            logic              cpu_hit;
            logic [DATA_W-1:0] cell_wdata;

            assign con_hit    = con_we_i && (con_level_i == LVL_W'(l))
                                && (con_num_i == NUM_W'(r + 1));
            assign cpu_hit    = wr_en_i && (level_i == LVL_W'(l))
                                && (wr_num_i == NUM_W'(r + 1));
            assign cell_wdata = con_hit ? con_wdata_i : wr_data_i;

            ixr_cell #(.DATA_W(DATA_W)) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .we     (con_hit | cpu_hit),
                .wdata  (cell_wdata),
                .word_o (words[l][r])
            );
        end
    end

    ixr_rdport #(.DATA_W(DATA_W), .LEVELS(LEVELS), .REGS(REGS)) u_rd_cpu (
        .clk     (clk),
        .rst_n   (rst_n),
        .words_i (words),
        .lvl_i   (level_i),
        .num_i   (rd_num_i),
        .data_o  (rd_data_o),
        .perr_o  (rd_perr_o)
    );

    ixr_rdport #(.DATA_W(DATA_W), .LEVELS(LEVELS), .REGS(REGS)) u_rd_con (
        .clk     (clk),
        .rst_n   (rst_n),
        .words_i (words),
        .lvl_i   (con_level_i),
        .num_i   (con_num_i),
        .data_o  (con_rdata_o),
        .perr_o  (con_perr_o)
    );
endmodule

// File: rtl/ixr_file_chk.sv
module ixr_file_chk #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned LEVELS = 4,
    parameter int unsigned REGS   = 7,
    localparam int unsigned LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1,
    localparam int unsigned NUM_W = $clog2(REGS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [LVL_W-1:0]  level_i,
    input logic              wr_en_i,
    input logic [NUM_W-1:0]  wr_num_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [NUM_W-1:0]  rd_num_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic              rd_perr_o,
    input logic [LVL_W-1:0]  con_level_i,
    input logic              con_we_i,
    input logic [NUM_W-1:0]  con_num_i,
    input logic [DATA_W-1:0] con_wdata_i,
    input logic [DATA_W-1:0] con_rdata_o,
    input logic              con_perr_o
);
    logic collide;
    assign collide = wr_en_i && con_we_i && (wr_num_i == con_num_i)
                     && (level_i == con_level_i) && (wr_num_i != '0);

    // R4: number 0 on the processor read port yields zero, no error
    p_zero_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_num_i == '0) |=> (rd_data_o == '0 && !rd_perr_o));

    // R4: number 0 on the console read port yields zero, no error
    p_zero_con_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (con_num_i == '0) |=> (con_rdata_o == '0 && !con_perr_o));

    // R2: written value returned on the following read of the same register
    p_wr_rd_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(wr_en_i) && $past(wr_num_i) != '0 && !$past(collide)
         && rd_num_i == $past(wr_num_i) && level_i == $past(level_i))
        |=> (rd_data_o == $past(wr_data_i, 2)));

    // R7: the console write survives a collision
    p_con_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(collide) && con_num_i == $past(con_num_i)
         && con_level_i == $past(con_level_i))
        |=> (con_rdata_o == $past(con_wdata_i, 2)));

    // R5: error flags are always defined once out of reset
    p_perr_known_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$isunknown({rd_perr_o, con_perr_o}));
endmodule

bind ixr_file ixr_file_chk #(.DATA_W(DATA_W), .LEVELS(LEVELS), .REGS(REGS)) u_chk (.*);

// File: tb/tb_ixr_file.sv
module tb_ixr_file;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  level_i = '0;
    logic        wr_en_i = 1'b0;
    logic [2:0]  wr_num_i = '0;
    logic [15:0] wr_data_i = '0;
    logic [2:0]  rd_num_i = '0;
    logic [15:0] rd_data_o;
    logic        rd_perr_o;
    logic [1:0]  con_level_i = '0;
    logic        con_we_i = 1'b0;
    logic [2:0]  con_num_i = '0;
    logic [15:0] con_wdata_i = '0;
    logic [15:0] con_rdata_o;
    logic        con_perr_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    ixr_file dut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [1:0] l, input logic [2:0] n, input logic [15:0] d);
        level_i = l; wr_num_i = n; wr_data_i = d; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic con_write(input logic [1:0] l, input logic [2:0] n, input logic [15:0] d);
        con_level_i = l; con_num_i = n; con_wdata_i = d; con_we_i = 1'b1;
        @(negedge clk);
        con_we_i = 1'b0;
    endtask

    task automatic cpu_read(input logic [1:0] l, input logic [2:0] n,
                            output logic [15:0] d, output logic e);
        level_i = l; rd_num_i = n;
        @(negedge clk);
        d = rd_data_o; e = rd_perr_o;
    endtask

    task automatic con_read(input logic [1:0] l, input logic [2:0] n,
                            output logic [15:0] d, output logic e);
        con_level_i = l; con_num_i = n;
        @(negedge clk);
        d = con_rdata_o; e = con_perr_o;
    endtask

    task automatic t_reset;
        logic [15:0] d; logic e; int bad;
        bad = 0;
        for (int l = 0; l < 4; l++) begin
            for (int n = 0; n < 8; n++) begin
                cpu_read(2'(l), 3'(n), d, e);
                if (d != 0 || e) bad++;
                con_read(2'(l), 3'(n), d, e);
                if (d != 0 || e) bad++;
            end
        end
        check(bad == 0, "R1 reset contents", bad, 0);
    endtask

    task automatic t_write_read;
        logic [15:0] d; logic e;
        cpu_write(2'd0, 3'd3, 16'hA5C3);
        cpu_read(2'd0, 3'd3, d, e);
        check(d == 16'hA5C3, "R2 readback", d, 16'hA5C3);
        cpu_write(2'd0, 3'd7, 16'hFFFF);
        cpu_read(2'd0, 3'd7, d, e);
        check(d == 16'hFFFF, "R2 readback reg7", d, 16'hFFFF);
        check(!e, "R9 clean parity FFFF", e, 0);
        cpu_write(2'd0, 3'd1, 16'h0100);
        cpu_read(2'd0, 3'd1, d, e);
        check(d == 16'h0100 && !e, "R9 clean parity 0100", {d, 15'd0, e}, 32'h0100_0000);
    endtask

    task automatic t_banks;
        logic [15:0] d; logic e;
        cpu_write(2'd2, 3'd3, 16'h1234);
        cpu_read(2'd0, 3'd3, d, e);
        check(d == 16'hA5C3, "R3 level0 untouched", d, 16'hA5C3);
        cpu_read(2'd2, 3'd3, d, e);
        check(d == 16'h1234, "R3 level2 value", d, 16'h1234);
        cpu_read(2'd1, 3'd3, d, e);
        check(d == 16'h0000, "R3 level1 untouched", d, 0);
    endtask

    task automatic t_zero;
        logic [15:0] d; logic e; int bad;
        cpu_write(2'd1, 3'd0, 16'hDEAD);
        con_write(2'd1, 3'd0, 16'hBEEF);
        bad = 0;
        for (int n = 1; n < 8; n++) begin
            cpu_read(2'd1, 3'(n), d, e);
            if (d != 0) bad++;
        end
        check(bad == 0, "R4 write to 0 ignored", bad, 0);
        cpu_read(2'd1, 3'd0, d, e);
        check(d == 0 && !e, "R4 read 0 cpu", {d, 15'd0, e}, 0);
        con_read(2'd1, 3'd0, d, e);
        check(d == 0 && !e, "R4 read 0 console", {d, 15'd0, e}, 0);
    endtask

    task automatic t_console;
        logic [15:0] d; logic e;
        level_i = 2'd0;
        con_write(2'd3, 3'd5, 16'h5555);
        con_read(2'd3, 3'd5, d, e);
        check(d == 16'h5555 && !e, "R6 console readback", d, 16'h5555);
        cpu_read(2'd0, 3'd5, d, e);
        check(d == 16'h0000, "R6 console ignores running level", d, 0);
        cpu_read(2'd3, 3'd5, d, e);
        check(d == 16'h5555, "R6 cpu sees console write at level3", d, 16'h5555);
        level_i = 2'd1;
        con_read(2'd2, 3'd3, d, e);
        check(d == 16'h1234, "R6 console reads level2 while level1 runs", d, 16'h1234);
    endtask

    task automatic t_collision;
        logic [15:0] d; logic e;
        level_i = 2'd1; wr_num_i = 3'd2; wr_data_i = 16'h1111; wr_en_i = 1'b1;
        con_level_i = 2'd1; con_num_i = 3'd2; con_wdata_i = 16'h2222; con_we_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; con_we_i = 1'b0;
        cpu_read(2'd1, 3'd2, d, e);
        check(d == 16'h2222, "R7 console wins", d, 16'h2222);
        level_i = 2'd1; wr_num_i = 3'd4; wr_data_i = 16'h4444; wr_en_i = 1'b1;
        con_level_i = 2'd2; con_num_i = 3'd4; con_wdata_i = 16'h8888; con_we_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0; con_we_i = 1'b0;
        cpu_read(2'd1, 3'd4, d, e);
        check(d == 16'h4444, "R7 distinct targets both written cpu", d, 16'h4444);
        con_read(2'd2, 3'd4, d, e);
        check(d == 16'h8888, "R7 distinct targets both written con", d, 16'h8888);
    endtask

    task automatic t_rdw;
        level_i = 2'd0; rd_num_i = 3'd6;
        wr_num_i = 3'd6; wr_data_i = 16'h7777; wr_en_i = 1'b1;
        @(negedge clk);
        wr_en_i = 1'b0;
        check(rd_data_o == 16'h0000, "R8 old value on collision read", rd_data_o, 0);
        @(negedge clk);
        check(rd_data_o == 16'h7777, "R8 new value next cycle", rd_data_o, 16'h7777);
    endtask

    task automatic t_parity;
        logic [15:0] d; logic e;
        cpu_write(2'd2, 3'd1, 16'h0000);
        force dut.g_lvl[2].g_reg[0].u_cell.word_q = 18'h10000;
        cpu_read(2'd2, 3'd1, d, e);
        check(e == 1'b1, "R5 high byte error cpu", e, 1);
        con_read(2'd2, 3'd1, d, e);
        check(e == 1'b1, "R5 high byte error console", e, 1);
        force dut.g_lvl[2].g_reg[0].u_cell.word_q = 18'h20000;
        cpu_read(2'd2, 3'd1, d, e);
        check(e == 1'b1, "R5 low byte error", e, 1);
        force dut.g_lvl[2].g_reg[0].u_cell.word_q = 18'h30080;
        cpu_read(2'd2, 3'd1, d, e);
        check(e == 1'b1 && d == 16'h0080, "R5 low byte error with data", {d, 15'd0, e},
              {16'h0080, 16'h0001});
        force dut.g_lvl[2].g_reg[0].u_cell.word_q = 18'h20001;
        cpu_read(2'd2, 3'd1, d, e);
        check(e == 1'b0 && d == 16'h0001, "R5 per-byte odd parity accepted", {d, 15'd0, e},
              {16'h0001, 16'h0000});
        release dut.g_lvl[2].g_reg[0].u_cell.word_q;
        cpu_write(2'd2, 3'd1, 16'h00FF);
        cpu_read(2'd2, 3'd1, d, e);
        check(e == 1'b0 && d == 16'h00FF, "R9 rewrite restores parity", {d, 15'd0, e},
              {16'h00FF, 16'h0000});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_banks();
        t_zero();
        t_console();
        t_collision();
        t_rdw();
        t_parity();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule